// File: doc/BRIEF.md
# Credit-Gated AXI4 Burst Read Engine

This block is an AXI4 memory-mapped read master. It fetches a run of fixed 1 KB INCR bursts from external memory and places the returned words into an internal receive FIFO. A downstream consumer drains the FIFO through a valid/ready pop port. A start pulse launches a job, using a start address and the number of bursts. A one-cycle done pulse marks the job's end.

Before it raises a read address request, the engine checks that the FIFO can hold the whole burst. It keeps a credit count of free FIFO words. The count falls by one burst's worth of beats at each address handshake and rises by one for each word the consumer pops. Space for every outstanding beat is therefore reserved in advance. The engine can then hold rready high for the whole job, and the interconnect is never left with read data it cannot hand over.

Every burst starts on a 1 KB boundary, so no burst can span a 4 KB page. A start address that is not 1 KB aligned is refused with a one-cycle reject pulse. Any response code other than OKAY on a data beat sets a sticky error flag. The next accepted job clears that flag.

Top module: `axi_burst_reader`

## Requirements
- R1: While reset is held and in the first cycle after it is released, arvalid, rready, done, rejected, busy, rd_err and q_valid are all low.
- R2: Every read address request carries arlen = BEATS-1 (127 for a 64-bit bus and 1 KB bursts), arsize = log2 of the bus width in bytes (3), arburst = 2'b01 (INCR) and arid = 0. The addresses of a job are start_addr, start_addr+1024, start_addr+2048, and so on, one per burst. araddr and arvalid stay stable while arvalid waits for arready.
- R3: An address handshake happens only when the free FIFO credit is at least BEATS. Credit starts at FIFO_DEPTH, drops by BEATS at each handshake and rises by 1 per popped word. With the defaults (depth 256) and no pops, at most 2 bursts are requested.
- R4: rready is high in every cycle in which an issued burst has not yet delivered its rlast beat.
- R5: Every beat accepted with rvalid and rready is pushed into the FIFO. Beats are popped in arrival order, and no word is lost or repeated.
- R6: done is a single-cycle pulse. It is raised in the cycle after the beat where rvalid, rready and rlast are high for the last burst of the job.
- R7: A start whose address has any of its low 10 bits set raises rejected for one cycle and issues no request. No burst of an accepted job crosses a 4 KB boundary.
- R8: A start with burst_cnt = 0 produces one done pulse and issues no request.
- R9: A start pulse while busy is high is ignored. The running job keeps its addresses and its burst count.
- R10: Any rresp other than 2'b00 on an accepted beat sets rd_err. rd_err stays set until the next accepted start, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a job (taken only when idle) |
| start_addr | input | ADDR_W | Byte address of the first burst |
| burst_cnt | input | CNT_W | Number of 1 KB bursts in the job |
| done | output | 1 | One-cycle pulse at job completion |
| rejected | output | 1 | One-cycle pulse for a misaligned start |
| busy | output | 1 | A job is in progress |
| rd_err | output | 1 | Sticky non-OKAY response flag |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_araddr | output | ADDR_W | Read address |
| m_arlen | output | 8 | Burst length minus one |
| m_arsize | output | 3 | Beat size code |
| m_arburst | output | 2 | Burst type (INCR) |
| m_arid | output | ID_W | Transaction ID, always zero |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| m_rdata | input | DATA_W | Read data |
| m_rresp | input | 2 | Read response code |
| m_rlast | input | 1 | Last beat of a burst |
| q_valid | output | 1 | FIFO holds a word |
| q_ready | input | 1 | Consumer takes the head word |
| q_data | output | DATA_W | FIFO head word |

## Verification
The sharpest corner is a consumer that stops popping. The bench stalls the pop port and confirms that only two bursts are requested, with a third appearing only after 128 words drain. A design that reserved credit per beat, or too late, would overrun the FIFO or lose data. A start pulse arriving mid-job must not redirect the address stream or change the burst count, or the data sequence check breaks. Misaligned and zero-length starts are aimed at designs that would issue a page-crossing burst or hang waiting for an rlast that never comes. An error response is injected on a later burst to confirm the flag stays set and clears only on the next accepted job.

// File: rtl/rrq_pkg.sv
package rrq_pkg;
  localparam logic [1:0] AXI_RESP_OKAY  = 2'b00;
  localparam logic [1:0] AXI_BURST_INCR = 2'b01;
endpackage

// File: rtl/rrq_credit.sv
// Free-space credit for the receive FIFO: reserved per burst, returned per pop.
module rrq_credit #(
  parameter int DEPTH = 256,
  parameter int BEATS = 128,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic give,
  output logic enough
);
  logic [CW-1:0] credit;

  always_ff @(posedge clk) begin
    if (rst) credit <= CW'(DEPTH);
    else     credit <= credit - (take ? CW'(BEATS) : '0) + (give ? CW'(1) : '0);
  end

  assign enough = (credit >= CW'(BEATS));

  AST_CREDIT_CAP: assert property (@(posedge clk) disable iff (rst)
    credit <= CW'(DEPTH)); // R3
endmodule

// File: rtl/rrq_fifo.sv
// Receive FIFO; memory written without reset so it maps onto RAM.
module rrq_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 256,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         not_empty
);
  logic [W-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   count;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= wp + PW'(1);
      if (pop)  rp <= rp + PW'(1);
      case ({push, pop})
        2'b10:   count <= count + (PW+1)'(1);
        2'b01:   count <= count - (PW+1)'(1);
        default: count <= count;
      endcase
    end
  end

  assign dout      = mem[rp];
  assign not_empty = (count != '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push |-> (count != (PW+1)'(DEPTH))); // R3
  AST_FIFO_ORDER_PTRS: assert property (@(posedge clk) disable iff (rst)
    (count == '0) |-> (wp == rp)); // R5
endmodule

// File: rtl/rrq_seq.sv
// Job control, address generation and completion tracking.
module rrq_seq
  import rrq_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 16,
  parameter int BURST_BYTES = 1024,
  localparam int OFF_W      = $clog2(BURST_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  burst_cnt,
  input  logic              enough,
  input  logic              arready,
  output logic              arvalid,
  output logic [ADDR_W-1:0] araddr,
  input  logic              rvalid,
  input  logic              rlast,
  input  logic [1:0]        rresp,
  output logic              rready,
  output logic              done,
  output logic              rejected,
  output logic              busy,
  output logic              rd_err
);
  logic [CNT_W-1:0] ar_left;
  logic [CNT_W-1:0] r_left;
  logic             misaligned;
  logic             beat_ok;

  assign misaligned = (start_addr[OFF_W-1:0] != '0);
  assign beat_ok    = rvalid && busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      arvalid  <= 1'b0;
      araddr   <= '0;
      ar_left  <= '0;
      r_left   <= '0;
      done     <= 1'b0;
      rejected <= 1'b0;
      rd_err   <= 1'b0;
    end else begin
      done     <= 1'b0;
      rejected <= 1'b0;
      if (!busy) begin
        if (start) begin
          if (misaligned) begin
            rejected <= 1'b1;
          end else if (burst_cnt == '0) begin
            done   <= 1'b1;
            rd_err <= 1'b0;
          end else begin
            busy    <= 1'b1;
            ar_left <= burst_cnt;
            r_left  <= burst_cnt;
            araddr  <= start_addr;
            rd_err  <= 1'b0;
          end
        end
      end else begin
        if (arvalid && arready) begin
          arvalid <= 1'b0;
          araddr  <= araddr + ADDR_W'(BURST_BYTES);
          ar_left <= ar_left - CNT_W'(1);
        end else if (!arvalid && (ar_left != '0) && enough) begin
          arvalid <= 1'b1;
        end
        if (beat_ok) begin
          if (rresp != AXI_RESP_OKAY) rd_err <= 1'b1;
          if (rlast) begin
            r_left <= r_left - CNT_W'(1);
            if (r_left == CNT_W'(1)) begin
              busy <= 1'b0;
              done <= 1'b1;
            end
          end
        end
      end
    end
  end

  assign rready = busy;

  AST_AR_HOLD: assert property (@(posedge clk) disable iff (rst)
    arvalid && !arready |=> arvalid && $stable(araddr)); // R2
  AST_AR_4K: assert property (@(posedge clk) disable iff (rst)
    arvalid |-> ((13'(araddr[11:0]) + 13'(BURST_BYTES)) <= 13'd4096)); // R7
  AST_RREADY_HELD: assert property (@(posedge clk) disable iff (rst)
    rready && !(rvalid && rlast && (r_left == CNT_W'(1))) |=> rready); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done && !start |=> !done); // R6
  AST_IDLE_NO_AR: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !arvalid); // R9
endmodule

// File: rtl/axi_burst_reader.sv
module axi_burst_reader
  import rrq_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 64,
  parameter int ID_W        = 4,
  parameter int CNT_W       = 16,
  parameter int BURST_BYTES = 1024,
  parameter int FIFO_DEPTH  = 256,
  localparam int BYTES_BEAT = DATA_W / 8,
  localparam int BEATS      = BURST_BYTES / BYTES_BEAT,
  localparam int SIZE_CODE  = $clog2(BYTES_BEAT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  burst_cnt,
  output logic              done,
  output logic              rejected,
  output logic              busy,
  output logic              rd_err,
  output logic              m_arvalid,
  input  logic              m_arready,
  output logic [ADDR_W-1:0] m_araddr,
  output logic [7:0]        m_arlen,
  output logic [2:0]        m_arsize,
  output logic [1:0]        m_arburst,
  output logic [ID_W-1:0]   m_arid,
  input  logic              m_rvalid,
  output logic              m_rready,
  input  logic [DATA_W-1:0] m_rdata,
  input  logic [1:0]        m_rresp,
  input  logic              m_rlast,
  output logic              q_valid,
  input  logic              q_ready,
  output logic [DATA_W-1:0] q_data
);
  logic ar_fire, pop_fire, r_fire, cred_ok;

  assign ar_fire  = m_arvalid && m_arready;
  assign pop_fire = q_valid && q_ready;
  assign r_fire   = m_rvalid && m_rready;

  rrq_credit #(.DEPTH(FIFO_DEPTH), .BEATS(BEATS)) u_credit (
    .clk(clk), .rst(rst), .take(ar_fire), .give(pop_fire), .enough(cred_ok)
  );

  rrq_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(r_fire), .din(m_rdata),
    .pop(pop_fire), .dout(q_data), .not_empty(q_valid)
  );

  rrq_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BURST_BYTES(BURST_BYTES)) u_seq (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .burst_cnt(burst_cnt), .enough(cred_ok), .arready(m_arready),
    .arvalid(m_arvalid), .araddr(m_araddr), .rvalid(m_rvalid),
    .rlast(m_rlast), .rresp(m_rresp), .rready(m_rready), .done(done),
    .rejected(rejected), .busy(busy), .rd_err(rd_err)
  );

  assign m_arlen   = 8'(BEATS - 1);
  assign m_arsize  = 3'(SIZE_CODE);
  assign m_arburst = AXI_BURST_INCR;
  assign m_arid    = '0;

  AST_AR_NEEDS_CREDIT: assert property (@(posedge clk) disable iff (rst)
    ar_fire |-> cred_ok); // R3
  AST_R_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    r_fire |-> busy); // R5
endmodule

// File: tb/tb_axi_burst_reader.sv
module tb_axi_burst_reader;
  localparam int CLK_PERIOD = 10;
  localparam int BEATS      = 128;
  localparam int BB         = 1024;
  localparam int LIMIT      = 30000;

  typedef struct packed {
    logic [31:0] addr;
    logic [15:0] cnt;
    logic [1:0]  mode;
    logic        rej;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'h0000_1000, 16'd1, 2'd0, 1'b0},
    '{32'h0000_0C00, 16'd3, 2'd1, 1'b0},
    '{32'h0001_0400, 16'd5, 2'd2, 1'b0},
    '{32'h0000_0200, 16'd2, 2'd0, 1'b1},
    '{32'h0000_2000, 16'd0, 2'd0, 1'b0},
    '{32'h0000_3C04, 16'd1, 2'd1, 1'b1}
  };

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [31:0] start_addr = '0;
  logic [15:0] burst_cnt = '0;
  logic done, rejected, busy, rd_err;
  logic m_arvalid, m_arready, m_rready, m_rvalid, m_rlast;
  logic [31:0] m_araddr;
  logic [7:0] m_arlen;
  logic [2:0] m_arsize;
  logic [1:0] m_arburst, m_rresp;
  logic [3:0] m_arid;
  logic [63:0] m_rdata, q_data;
  logic q_valid;
  logic q_ready = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  axi_burst_reader dut (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .burst_cnt(burst_cnt), .done(done), .rejected(rejected), .busy(busy),
    .rd_err(rd_err), .m_arvalid(m_arvalid), .m_arready(m_arready),
    .m_araddr(m_araddr), .m_arlen(m_arlen), .m_arsize(m_arsize),
    .m_arburst(m_arburst), .m_arid(m_arid), .m_rvalid(m_rvalid),
    .m_rready(m_rready), .m_rdata(m_rdata), .m_rresp(m_rresp),
    .m_rlast(m_rlast), .q_valid(q_valid), .q_ready(q_ready), .q_data(q_data)
  );

  int total = 0, bad = 0;
  // slave and monitor state
  logic [31:0] qa [16];
  int wq = 0, rq = 0, beat = 0, cyc = 0;
  logic gate = 1'b0;
  logic err_en = 1'b0;
  logic [31:0] err_addr = '0;
  logic [1:0] pop_mode = 2'd3;
  logic [31:0] exp_ar = '0;
  logic [63:0] exp_data = '0;
  int tb_credit = 256;
  int ar_cnt, ar_bad, rdone, pop_cnt, data_bad, done_cnt, rej_cnt, credit_bad, rdrop;

  assign m_arready = (cyc % 3) != 1;
  assign m_rvalid  = (wq != rq) && gate;
  assign m_rdata   = 64'(qa[rq % 16]) + 64'(beat * 8);
  assign m_rlast   = (beat == BEATS - 1);
  assign m_rresp   = (err_en && qa[rq % 16] == err_addr && beat == 5) ? 2'b10 : 2'b00;

  always @(posedge clk) begin
    cyc  <= cyc + 1;
    gate <= (cyc % 5) != 0;
    q_ready <= (pop_mode == 2'd0) || (pop_mode == 2'd1 && cyc % 2 == 0) ||
               (pop_mode == 2'd2 && cyc % 4 == 0);
    if (!rst) begin
      if (m_arvalid && m_arready) begin
        if (m_arlen != 8'd127 || m_arsize != 3'd3 || m_arburst != 2'b01 ||
            m_arid != 4'd0 || m_araddr != exp_ar) ar_bad++;
        if (tb_credit < BEATS) credit_bad++;
        tb_credit -= BEATS;
        exp_ar += 32'(BB);
        qa[wq % 16] <= m_araddr;
        wq <= wq + 1;
        ar_cnt++;
      end
      if (m_rvalid && m_rready) begin
        if (m_rlast) begin beat <= 0; rq <= rq + 1; rdone++; end
        else beat <= beat + 1;
      end
      if (q_valid && q_ready) begin
        if (q_data != exp_data) data_bad++;
        exp_data += 64'd8;
        pop_cnt++;
        tb_credit++;
      end
      if (done) done_cnt++;
      if (rejected) rej_cnt++;
    end
  end

  always @(negedge clk) begin
    if (!rst && ar_cnt > rdone && !m_rready) rdrop++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_counts(input logic [31:0] a);
    ar_cnt = 0; ar_bad = 0; rdone = 0; pop_cnt = 0; data_bad = 0;
    done_cnt = 0; rej_cnt = 0; credit_bad = 0; rdrop = 0;
    exp_ar = a; exp_data = 64'(a);
  endtask

  task automatic launch(input logic [31:0] a, input logic [15:0] n);
    @(posedge clk);
    start <= 1'b1; start_addr <= a; burst_cnt <= n;
    @(posedge clk);
    start <= 1'b0;
  endtask

  task automatic finish_wait(input int words);
    int w = 0;
    while (done_cnt == 0 && rej_cnt == 0 && w < LIMIT) begin @(negedge clk); w++; end
    while (pop_cnt < words && w < LIMIT) begin @(negedge clk); w++; end
    repeat (4) @(negedge clk);
    check(w < LIMIT, "R6", "job completion wait", w, LIMIT);
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    report();
  end

  initial begin
    clear_counts('0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!m_arvalid && !m_rready && !done, "R1", "ar/r/done in reset", 0, 0);
    @(posedge clk); rst <= 1'b0;
    @(negedge clk);
    check(!m_arvalid, "R1", "arvalid after reset", m_arvalid, 0);
    check(!m_rready,  "R1", "rready after reset",  m_rready, 0);
    check(!done && !rejected && !busy, "R1", "done/rejected/busy after reset",
          {done, rejected, busy}, 0);
    check(!rd_err && !q_valid, "R1", "rd_err/q_valid after reset", {rd_err, q_valid}, 0);

    // vector table
    for (int i = 0; i < 6; i++) begin
      clear_counts(VECS[i].addr);
      pop_mode = VECS[i].mode;
      launch(VECS[i].addr, VECS[i].cnt);
      finish_wait(int'(VECS[i].cnt) * (VECS[i].rej ? 0 : BEATS));
      if (VECS[i].rej) begin
        check(rej_cnt == 1, "R7", "reject pulses", rej_cnt, 1);
        check(ar_cnt == 0 && done_cnt == 0, "R7", "requests after reject", ar_cnt, 0);
      end else if (VECS[i].cnt == 0) begin
        check(done_cnt == 1, "R8", "done pulses for zero count", done_cnt, 1);
        check(ar_cnt == 0, "R8", "requests for zero count", ar_cnt, 0);
      end else begin
        check(done_cnt == 1, "R6", "done pulses", done_cnt, 1);
        check(ar_cnt == int'(VECS[i].cnt), "R2", "request count", ar_cnt, VECS[i].cnt);
        check(ar_bad == 0, "R2", "bad request fields/addresses", ar_bad, 0);
        check(pop_cnt == int'(VECS[i].cnt) * BEATS, "R5", "words popped",
              pop_cnt, int'(VECS[i].cnt) * BEATS);
        check(data_bad == 0, "R5", "out-of-order or wrong words", data_bad, 0);
        check(rdrop == 0, "R4", "cycles rready low while outstanding", rdrop, 0);
        check(credit_bad == 0, "R3", "handshakes without credit", credit_bad, 0);
      end
    end

    // R3: consumer stalled, only two bursts fit
    clear_counts(32'h0002_0000);
    pop_mode = 2'd3;
    launch(32'h0002_0000, 16'd4);
    repeat (1500) @(negedge clk);
    check(ar_cnt == 2, "R3", "requests with stalled consumer", ar_cnt, 2);
    check(q_valid && done_cnt == 0, "R3", "fifo held, job open", done_cnt, 0);
    check(rdrop == 0, "R4", "rready while fifo full", rdrop, 0);
    pop_mode = 2'd0;
    finish_wait(4 * BEATS);
    check(ar_cnt == 4 && credit_bad == 0, "R3", "requests after drain", ar_cnt, 4);
    check(data_bad == 0 && pop_cnt == 4 * BEATS, "R5", "words after stall", pop_cnt, 4 * BEATS);

    // R9: start while busy ignored
    clear_counts(32'h0003_0000);
    pop_mode = 2'd1;
    launch(32'h0003_0000, 16'd2);
    repeat (10) @(negedge clk);
    launch(32'h0004_0000, 16'd3);
    finish_wait(2 * BEATS);
    check(ar_cnt == 2, "R9", "request count after busy start", ar_cnt, 2);
    check(ar_bad == 0 && data_bad == 0, "R9", "addresses/data after busy start",
          ar_bad + data_bad, 0);
    check(done_cnt == 1, "R9", "done pulses after busy start", done_cnt, 1);

    // R10: error response sticky, cleared by next accepted start
    clear_counts(32'h0005_0000);
    pop_mode = 2'd0;
    err_addr = 32'h0005_0400; err_en = 1'b1;
    launch(32'h0005_0000, 16'd2);
    finish_wait(2 * BEATS);
    check(rd_err == 1'b1, "R10", "rd_err after error beat", rd_err, 1);
    repeat (10) @(negedge clk);
    check(rd_err == 1'b1, "R10", "rd_err sticky", rd_err, 1);
    err_en = 1'b0;
    clear_counts(32'h0006_0000);
    launch(32'h0006_0000, 16'd1);
    @(negedge clk);
    check(rd_err == 1'b0, "R10", "rd_err cleared by start", rd_err, 0);
    finish_wait(BEATS);
    check(rd_err == 1'b0 && done_cnt == 1, "R10", "clean job leaves rd_err low", rd_err, 0);

    report();
  end
endmodule